// File: doc/BRIEF.md
# Serial Threshold Loader for FIFO Almost-Full and Almost-Empty Flags

This block sets the two fill-level thresholds of a 1024-word FIFO from a single serial bit stream and then turns external fill counts into almost-full and almost-empty flags. After a master reset, software or a board controller holds the serial enable low and presents one data bit per write-clock rising edge. The first ten bits form the almost-full offset and the next ten form the almost-empty offset, each most significant bit first. Until the twentieth bit has been taken, the block reports the write side as not ready and holds both flags in their reset state.

Once loading is done, the write-clock side registers an almost-full flag from the write-side count. The read-clock side registers an active-low almost-empty flag from the read-side count. The completion indication is brought into the read-clock domain through a two-stage synchronizer before the almost-empty flag may leave its reset value. A partial reset clears only the flag registers. The loaded offsets and the completion state survive it. A master reset clears everything, and a new stream may then be loaded.

Top module: `fifo_ofs_loader`

## Requirements
- R1: While and just after master reset (`mrst_n` low), `prog_done`, `in_ready`, `afull` and `aempty_n` are all 0.
- R2: A serial bit is taken only on a `wclk` rising edge where `ser_en_n` is 0. `prog_done` becomes 1 after exactly 20 such edges. Edges with `ser_en_n` at 1 do not count, whatever `ser_din` holds.
- R3: The bit taken first is bit 9 of the almost-full offset Y. The twentieth bit is bit 0 of the almost-empty offset X. Bits 1 to 10 are Y from bit 9 down to bit 0, and bits 11 to 20 are X from bit 9 down to bit 0.
- R4: `in_ready` is 0 while `prog_done` is 0. Afterwards it is 1 when `wr_count` is below 1024 and 0 when `wr_count` equals 1024.
- R5: After programming, `afull` takes the value (`wr_count` >= 1024 − Y) on the next `wclk` rising edge, for any Y from 0 to 1023. Before programming it stays 0.
- R6: After programming, and once `prog_done` has crossed into the read domain, `aempty_n` takes the value (`rd_count` > X) on the next `rclk` rising edge, for any X from 0 to 1023. Until then it stays 0.
- R7: Once `prog_done` is 1, further low pulses on `ser_en_n` with any `ser_din` leave both offsets unchanged, and `prog_done` stays 1.
- R8: While `prst_n` is 0, `afull` and `aempty_n` are 0. `prog_done` and both offsets are kept, and the flags follow the old thresholds again after `prst_n` returns to 1.
- R9: A master reset during loading discards the bits already taken. The next load again needs exactly 20 enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; also clocks the serial loader |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset of the flag registers, active low |
| ser_en_n | input | 1 | Serial load enable, active low |
| ser_din | input | 1 | Serial offset data bit |
| wr_count | input | 11 | Fill count as seen by the write side (0..1024) |
| rd_count | input | 11 | Fill count as seen by the read side (0..1024) |
| prog_done | output | 1 | High once all 20 offset bits are loaded |
| in_ready | output | 1 | Write side may accept a word |
| afull | output | 1 | Almost-full flag, active high |
| aempty_n | output | 1 | Almost-empty flag, active low (low means X or fewer words) |

## Verification
A miscounted or misordered shift shows up at the ports in one of two ways. Either `prog_done` rises one edge early or late, or the flag thresholds land at the wrong count. Loading a one-hot offset and probing both sides of its boundary exposes a swapped field or a reversed bit order within a single count step. A shift register that keeps accepting bits after completion would move a threshold on the very next enabled edge. A completion flag that is not synchronized properly would let `aempty_n` leave 0 before the read side could have seen it.

// File: rtl/thr_pkg.sv
package thr_pkg;

  // Almost-full condition: the free space is no larger than the offset.
  function automatic logic near_full(input logic [31:0] cnt,
                                     input logic [31:0] yofs,
                                     input logic [31:0] depth);
    return (cnt + yofs) >= depth;
  endfunction

  // Not-almost-empty condition: more words than the offset.
  function automatic logic past_low_mark(input logic [31:0] cnt,
                                         input logic [31:0] xofs);
    return cnt > xofs;
  endfunction

endpackage

// File: rtl/thr_ser_loader.sv
module thr_ser_loader #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          sen_n,
  input  logic          sdin,
  output logic [AW-1:0] ofs_y,
  output logic [AW-1:0] ofs_x,
  output logic          done,
  output logic          shift_evt
);
  localparam int NB   = 2 * AW;
  localparam int CNTW = $clog2(NB + 1);

  logic [NB-1:0]   sh_q;
  logic [CNTW-1:0] cnt_q;
  logic            done_q;
  logic            last_bit;

  assign shift_evt = !done_q && !sen_n;
  assign last_bit  = (cnt_q == CNTW'(NB - 1));

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (shift_evt) begin
      sh_q  <= {sh_q[NB-2:0], sdin};
      cnt_q <= cnt_q + 1'b1;
      if (last_bit) done_q <= 1'b1;
    end
  end

  // Y occupies the upper half: its MSB went in first.
  assign ofs_y = sh_q[NB-1:AW];
  assign ofs_x = sh_q[AW-1:0];
  assign done  = done_q;

  a_r2_cnt_limit: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt_q <= CNTW'(NB));
  a_r2_done_on_last: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(done_q) |-> cnt_q == CNTW'(NB));
  a_r2_count_moves: assert property (@(posedge clk) disable iff (!mrst_n)
    shift_evt |=> cnt_q != $past(cnt_q));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
    done_q |=> ($stable(sh_q) && $stable(cnt_q) && done_q));
endmodule

// File: rtl/thr_full_side.sv
module thr_full_side #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          done,
  input  logic [AW:0]   cnt,
  input  logic [AW-1:0] ofs_y,
  output logic          afull,
  output logic          in_ready
);
  import thr_pkg::*;

  logic rst_n;
  logic af_hit;
  logic afull_q;

  assign rst_n  = mrst_n && prst_n;
  assign af_hit = near_full(32'(cnt), 32'(ofs_y), 32'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) afull_q <= 1'b0;
    else        afull_q <= done && af_hit;
  end

  assign afull    = afull_q;
  assign in_ready = done && (cnt < (AW+1)'(DEPTH));

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !afull_q);
endmodule

// File: rtl/thr_empty_side.sv
module thr_empty_side #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          done_w,
  input  logic [AW:0]   cnt,
  input  logic [AW-1:0] ofs_x,
  output logic          aempty_n,
  output logic          done_r
);
  import thr_pkg::*;

  logic rst_n;
  logic done_m, done_s;
  logic ae_ok;
  logic aen_q;

  assign rst_n = mrst_n && prst_n;
  assign ae_ok = past_low_mark(32'(cnt), 32'(ofs_x));

  // Completion crosses from the write clock through two stages.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      done_m <= 1'b0;
      done_s <= 1'b0;
    end else begin
      done_m <= done_w;
      done_s <= done_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aen_q <= 1'b0;
    else        aen_q <= done_s && ae_ok;
  end

  assign aempty_n = aen_q;
  assign done_r   = done_s;

  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !done_s |=> !aen_q);
  a_r6_sync_order: assert property (@(posedge clk) disable iff (!mrst_n)
    done_s |-> done_m);
endmodule

// File: rtl/fifo_ofs_loader.sv
module fifo_ofs_loader #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        mrst_n,
  input  logic        prst_n,
  input  logic        ser_en_n,
  input  logic        ser_din,
  input  logic [AW:0] wr_count,
  input  logic [AW:0] rd_count,
  output logic        prog_done,
  output logic        in_ready,
  output logic        afull,
  output logic        aempty_n
);
  logic [AW-1:0] ofs_y, ofs_x;
  logic          done_w, done_r, shift_evt;

  thr_ser_loader #(.AW(AW)) u_load (
    .clk(wclk), .mrst_n(mrst_n), .sen_n(ser_en_n), .sdin(ser_din),
    .ofs_y(ofs_y), .ofs_x(ofs_x), .done(done_w), .shift_evt(shift_evt)
  );

  thr_full_side #(.DEPTH(DEPTH), .AW(AW)) u_full (
    .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .done(done_w),
    .cnt(wr_count), .ofs_y(ofs_y), .afull(afull), .in_ready(in_ready)
  );

  thr_empty_side #(.AW(AW)) u_empty (
    .clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .done_w(done_w),
    .cnt(rd_count), .ofs_x(ofs_x), .aempty_n(aempty_n), .done_r(done_r)
  );

  assign prog_done = done_w;

  a_r4_no_ready_early: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prog_done |-> !in_ready);
  a_r4_full_flags_af: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    (prog_done && $past(prog_done) && wr_count == (AW+1)'(DEPTH)) |=> afull);
  a_r2_no_shift_after: assert property (@(posedge wclk) disable iff (!mrst_n)
    prog_done |-> !shift_evt);
  a_r6_read_after_write: assert property (@(posedge rclk) disable iff (!mrst_n)
    done_r |-> prog_done);
endmodule

// File: tb/fifo_ofs_loader_tb.sv
`timescale 1ns/1ps
module fifo_ofs_loader_tb;
  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, ser_en_n = 1'b1, ser_din = 1'b0;
  logic [10:0] wr_count = '0, rd_count = '0;
  logic prog_done, in_ready, afull, aempty_n;
  int total = 0, bad = 0;

  always #10 wclk = ~wclk;
  initial begin #5; forever #10 rclk = ~rclk; end

  fifo_ofs_loader u_dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .ser_en_n(ser_en_n), .ser_din(ser_din), .wr_count(wr_count),
    .rd_count(rd_count), .prog_done(prog_done), .in_ready(in_ready),
    .afull(afull), .aempty_n(aempty_n)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_mrst();
    @(negedge wclk);
    mrst_n = 1'b0; ser_en_n = 1'b1;
    repeat (2) @(negedge wclk);
    mrst_n = 1'b1;
    @(negedge wclk);
  endtask

  // Stream is {Y, X}; element 0 is the first bit sent.
  task automatic send_bits(input logic [19:0] s, input int from, input int upto,
                           input bit gaps);
    for (int i = from; i < upto; i++) begin
      ser_en_n = 1'b0; ser_din = s[19-i];
      @(negedge wclk);
      if (gaps) begin
        ser_en_n = 1'b1; ser_din = ~s[19-i];
        @(negedge wclk);
      end
    end
    ser_en_n = 1'b1;
  endtask

  task automatic probe(input int w, input int r, input int y, input int x, input string req);
    logic exp_af, exp_ae;
    wr_count = 11'(w); rd_count = 11'(r);
    repeat (4) @(negedge wclk);
    exp_af = (w >= 1024 - y);
    exp_ae = (r >= x + 1);
    check(afull == exp_af, req, int'(afull), int'(exp_af));
    check(aempty_n == exp_ae, req, int'(aempty_n), int'(exp_ae));
  endtask

  task automatic t_reset();
    mrst_n = 1'b0;
    repeat (3) @(negedge wclk);
    check(!prog_done, "R1", int'(prog_done), 0);
    check(!in_ready,  "R1", int'(in_ready), 0);
    check(!afull,     "R1", int'(afull), 0);
    check(!aempty_n,  "R1", int'(aempty_n), 0);
    mrst_n = 1'b1;
    @(negedge wclk);
    check(!prog_done && !in_ready, "R1", int'(prog_done), 0);
  endtask

  task automatic t_gap_load();
    logic [19:0] s = {10'd100, 10'd50};
    do_mrst();
    wr_count = 11'd1024; rd_count = 11'd1024;
    send_bits(s, 0, 19, 1'b1);
    check(!prog_done, "R2", int'(prog_done), 0);
    check(!in_ready, "R4", int'(in_ready), 0);
    check(!afull, "R5", int'(afull), 0);
    repeat (4) @(negedge wclk);
    check(!aempty_n, "R6", int'(aempty_n), 0);
    send_bits(s, 19, 20, 1'b0);
    check(prog_done, "R2", int'(prog_done), 1);
    probe(923, 50, 100, 50, "R5");
    probe(924, 51, 100, 50, "R6");
  endtask

  task automatic t_order();
    logic [19:0] s = {10'h200, 10'h001};
    do_mrst();
    send_bits(s, 0, 20, 1'b0);
    check(prog_done, "R3", int'(prog_done), 1);
    probe(511, 1, 512, 1, "R3");
    probe(512, 2, 512, 1, "R3");
  endtask

  task automatic t_bounds();
    do_mrst();
    send_bits({10'd0, 10'd1023}, 0, 20, 1'b0);
    probe(1023, 1023, 0, 1023, "R5");
    probe(1024, 1024, 0, 1023, "R6");
    do_mrst();
    send_bits({10'd1023, 10'd0}, 0, 20, 1'b0);
    probe(0, 0, 1023, 0, "R5");
    probe(1, 1, 1023, 0, "R6");
  endtask

  task automatic t_ready();
    do_mrst();
    send_bits({10'd5, 10'd5}, 0, 20, 1'b0);
    wr_count = 11'd1023;
    @(negedge wclk);
    check(in_ready, "R4", int'(in_ready), 1);
    wr_count = 11'd1024;
    @(negedge wclk);
    check(!in_ready, "R4", int'(in_ready), 0);
  endtask

  task automatic t_extra();
    do_mrst();
    send_bits({10'd300, 10'd200}, 0, 20, 1'b0);
    send_bits(20'hFFFFF, 0, 20, 1'b0);
    check(prog_done, "R7", int'(prog_done), 1);
    probe(723, 200, 300, 200, "R7");
    probe(724, 201, 300, 200, "R7");
  endtask

  task automatic t_prst();
    do_mrst();
    send_bits({10'd10, 10'd10}, 0, 20, 1'b0);
    probe(1020, 500, 10, 10, "R8");
    prst_n = 1'b0;
    @(negedge wclk); @(negedge wclk);
    check(!afull, "R8", int'(afull), 0);
    check(!aempty_n, "R8", int'(aempty_n), 0);
    check(prog_done, "R8", int'(prog_done), 1);
    prst_n = 1'b1;
    probe(1014, 11, 10, 10, "R8");
    probe(1013, 10, 10, 10, "R8");
  endtask

  task automatic t_mid_reset();
    do_mrst();
    send_bits(20'hFFFFF, 0, 7, 1'b0);
    do_mrst();
    send_bits({10'd64, 10'd32}, 0, 19, 1'b0);
    check(!prog_done, "R9", int'(prog_done), 0);
    send_bits({10'd64, 10'd32}, 19, 20, 1'b0);
    check(prog_done, "R9", int'(prog_done), 1);
    probe(960, 33, 64, 32, "R9");
    probe(959, 32, 64, 32, "R9");
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_gap_load();
    t_order();
    t_bounds();
    t_ready();
    t_extra();
    t_prst();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule